// File: doc/BRIEF.md
# Leaf Configuration Manager with Configuration Cache

This block sits at the bottom of a configuration-manager hierarchy and owns a small group of processing elements. It takes requests from its parent and from event lines raised by the array. It keeps recently used configurations in a local cache. It then streams configuration words onto a shared bus, one word per cycle, with each word naming an element, a field and a value. The block keeps a configured/free state bit for each element. A full configuration is written only into free elements. Each element becomes configured as soon as its last field is written, so it can start computing while later elements of the same configuration are still waiting.

A configuration is fetched from the parent on a cache miss. The fetch is a one-cycle request followed by a header beat and then the data beats. A prefetch fills the cache without touching the array, and a later load of that configuration needs no fetch. A differential configuration rewrites only selected fields of elements that are already configured. Elements return to free through per-element release lines driven by the array, or through a release request that frees every element of a cached configuration.

The controller is a single state machine with six states:
- Idle: waits for a queued request.
- Lookup: checks the cache tags.
- Fetch: raises the fetch pulse.
- Header: waits for the header beat.
- Fill: stores the data beats.
- Write: streams words to the bus.

Its transitions are:
- Idle to Lookup when the queue is non-empty.
- Lookup to Write on a load hit.
- Lookup to Fetch on a load or prefetch miss.
- Lookup to Idle on a prefetch hit, a release or a no-op.
- Fetch to Header unconditionally.
- Header to Fill when the header beat arrives.
- Fill to Write after the last beat of a load.
- Fill to Idle after the last beat of a prefetch.
- Write to Idle after the last element.

Top module: `lcm_leaf_mgr`

## Requirements
- R1: After reset every element is free, no bus write or fetch is issued, and `req_ready` is high.
- R2: A full load writes one word per cycle: the target elements in ascending index, and fields 0 to FIELDS-1 in ascending order within each. Each word carries the value of the filled data beat at position element*FIELDS+field.
- R3: A full load never writes into a configured element. It stalls at the first configured target, keeps the words already written to earlier targets, and resumes once that element is freed.
- R4: An element reads configured in the cycle after its last field is written, even while later targets of the same load are still stalled.
- R5: A differential configuration (header bit DW-1 set) writes only the fields selected in header bits [N_ELEM+FIELDS-1:N_ELEM], and only into targets that are already configured. It raises `cfg_partial` on those words, leaves element state unchanged, and skips free targets.
- R6: On a miss the block raises `fetch_req` for exactly one cycle with the request's identifier. It then takes one header beat (element mask in bits [N_ELEM-1:0]) followed by N_ELEM*FIELDS data beats, element-major, all marked by `fill_valid`.
- R7: A prefetch (op 1) fetches on a miss and never writes to the bus.
- R8: A configuration resident in the cache loads with no fetch. Slots are replaced round-robin, so after NSLOT further distinct fetches a configuration is fetched again.
- R9: A pulse on `rel_evt[e]` frees element e. A release request (op 2) for a cached configuration frees every element in its mask and issues no fetch.
- R10: Requests are serviced in arrival order (op 0 load, 1 prefetch, 2 release, 3 no-op). The event port takes priority over the parent port, and `req_ready` is low while `evt_valid` is high or the queue is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Parent request valid |
| req_op | input | 2 | Parent request operation |
| req_id | input | ID_W | Parent request configuration identifier |
| req_ready | output | 1 | Parent request accepted this cycle |
| evt_valid | input | 1 | Array event request valid |
| evt_op | input | 2 | Array event operation |
| evt_id | input | ID_W | Array event configuration identifier |
| fetch_req | output | 1 | One-cycle fetch request to the parent |
| fetch_id | output | ID_W | Identifier being fetched |
| fill_valid | input | 1 | Fill beat valid |
| fill_data | input | DW | Header or data beat |
| rel_evt | input | N_ELEM | Per-element release from the array |
| cfg_we | output | 1 | Configuration bus write strobe |
| cfg_elem | output | EW | Target element index |
| cfg_field | output | FW | Target field index |
| cfg_data | output | DW | Field value |
| cfg_partial | output | 1 | Word belongs to a differential update |
| elem_cfgd | output | N_ELEM | Per-element configured state |

## Verification
The hardest situation to reach is a full load that is part-way through: some targets are already written and configured, while the load waits on a later target still held by an earlier configuration. The stimulus first loads a configuration onto the high elements. It then requests a second configuration that overlaps only in its last element. The bench checks that the first free target is written and reads configured while the bus stays silent. Only then does it pulse the release line of the blocking element and expect the remaining words. A second hard case is queue order when the event and parent ports fire in the same cycle. There, a release arriving behind a load would leave the load stalled, so only event-first ordering produces the full expected write list.

// File: rtl/lcm_pkg.sv
package lcm_pkg;

    typedef enum logic [1:0] {
        OP_LOAD     = 2'd0,
        OP_PREFETCH = 2'd1,
        OP_RELEASE  = 2'd2,
        OP_NONE     = 2'd3
    } lcm_op_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_LOOKUP = 3'd1,
        ST_FETCH  = 3'd2,
        ST_HEADER = 3'd3,
        ST_FILL   = 3'd4,
        ST_WRITE  = 3'd5
    } lcm_state_e;

endpackage

// File: rtl/lcm_req_fifo.sv
module lcm_req_fifo #(
    parameter int W     = 6,
    parameter int DEPTH = 4,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    logic [W-1:0] mem_q [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [AW:0]   cnt_q;

    assign empty = (cnt_q == '0);
    assign full  = (cnt_q == (AW+1)'(DEPTH));
    assign dout  = mem_q[rp_q];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wp_q <= (wp_q == AW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
            if (pop)  rp_q <= (rp_q == AW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
            if (push && !pop)      cnt_q <= cnt_q + 1'b1;
            else if (pop && !push) cnt_q <= cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem_q[wp_q] <= din;
    end

    AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full); // R10
    AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty); // R10

endmodule

// File: rtl/lcm_cfg_cache.sv
module lcm_cfg_cache #(
    parameter int N_ELEM = 4,
    parameter int FIELDS = 4,
    parameter int NSLOT  = 4,
    parameter int ID_W   = 4,
    parameter int DW     = 16,
    localparam int BEATS = N_ELEM * FIELDS,
    localparam int SW    = (NSLOT > 1) ? $clog2(NSLOT) : 1,
    localparam int EW    = (N_ELEM > 1) ? $clog2(N_ELEM) : 1,
    localparam int FW    = (FIELDS > 1) ? $clog2(FIELDS) : 1,
    localparam int BW    = (BEATS > 1) ? $clog2(BEATS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ID_W-1:0]   lk_id,
    output logic              lk_hit,
    output logic [SW-1:0]     lk_slot,
    output logic [N_ELEM-1:0] lk_emask,
    input  logic              hdr_we,
    input  logic [SW-1:0]     hdr_slot,
    input  logic [ID_W-1:0]   hdr_id,
    input  logic [DW-1:0]     hdr_word,
    input  logic              dat_we,
    input  logic [SW-1:0]     dat_slot,
    input  logic [BW-1:0]     dat_beat,
    input  logic [DW-1:0]     dat_word,
    input  logic [SW-1:0]     rd_slot,
    input  logic [EW-1:0]     rd_elem,
    input  logic [FW-1:0]     rd_field,
    output logic [DW-1:0]     rd_word,
    output logic              rd_diff,
    output logic [N_ELEM-1:0] rd_emask,
    output logic [FIELDS-1:0] rd_fmask
);
    logic [NSLOT-1:0] vld_q;
    logic [NSLOT-1:0] hit_vec;
    logic [ID_W-1:0]  tag_q [NSLOT];
    logic [DW-1:0]    hdr_q [NSLOT];
    logic [DW-1:0]    dat_q [NSLOT*BEATS];

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        assign hit_vec[s] = vld_q[s] && (tag_q[s] == lk_id);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld_q[s] <= 1'b0;
                tag_q[s] <= '0;
                hdr_q[s] <= '0;
            end else if (hdr_we && (hdr_slot == SW'(s))) begin
                vld_q[s] <= 1'b1;
                tag_q[s] <= hdr_id;
                hdr_q[s] <= hdr_word;
            end
        end
    end

    always_comb begin
        lk_slot = '0;
        for (int s = 0; s < NSLOT; s++) begin
            if (hit_vec[s]) lk_slot = SW'(s);
        end
    end

    assign lk_hit   = |hit_vec;
    assign lk_emask = hdr_q[lk_slot][N_ELEM-1:0];

    always_ff @(posedge clk) begin
        if (dat_we) dat_q[int'(dat_slot)*BEATS + int'(dat_beat)] <= dat_word;
    end

    assign rd_word  = dat_q[int'(rd_slot)*BEATS + int'(rd_elem)*FIELDS + int'(rd_field)];
    assign rd_diff  = hdr_q[rd_slot][DW-1];
    assign rd_emask = hdr_q[rd_slot][N_ELEM-1:0];
    assign rd_fmask = hdr_q[rd_slot][N_ELEM+FIELDS-1:N_ELEM];

    AST_ONE_TAG_MATCH: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit_vec)); // R8
    AST_FILL_ONLY_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n) (hdr_we && hdr_id == lk_id) |-> !lk_hit); // R8

endmodule

// File: rtl/lcm_elem_track.sv
module lcm_elem_track #(
    parameter int N_ELEM = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_ELEM-1:0] set_vec,
    input  logic [N_ELEM-1:0] clr_vec,
    output logic [N_ELEM-1:0] cfgd
);
    for (genvar e = 0; e < N_ELEM; e++) begin : g_elem
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          cfgd[e] <= 1'b0;
            else if (set_vec[e]) cfgd[e] <= 1'b1;
            else if (clr_vec[e]) cfgd[e] <= 1'b0;
        end

        AST_RELEASE_FREES: assert property (@(posedge clk) disable iff (!rst_n) (clr_vec[e] && !set_vec[e]) |=> !cfgd[e]); // R9
    end

    AST_SET_ONLY_FREE: assert property (@(posedge clk) disable iff (!rst_n) (set_vec & cfgd) == '0); // R3

endmodule

// File: rtl/lcm_leaf_mgr.sv
module lcm_leaf_mgr
    import lcm_pkg::*;
#(
    parameter int N_ELEM = 4,
    parameter int FIELDS = 4,
    parameter int NSLOT  = 4,
    parameter int QDEPTH = 4,
    parameter int ID_W   = 4,
    parameter int DW     = 16,
    localparam int BEATS = N_ELEM * FIELDS,
    localparam int SW    = (NSLOT > 1) ? $clog2(NSLOT) : 1,
    localparam int EW    = (N_ELEM > 1) ? $clog2(N_ELEM) : 1,
    localparam int FW    = (FIELDS > 1) ? $clog2(FIELDS) : 1,
    localparam int BW    = (BEATS > 1) ? $clog2(BEATS) : 1,
    localparam int QW    = 2 + ID_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ID_W-1:0]   req_id,
    output logic              req_ready,
    input  logic              evt_valid,
    input  logic [1:0]        evt_op,
    input  logic [ID_W-1:0]   evt_id,
    output logic              fetch_req,
    output logic [ID_W-1:0]   fetch_id,
    input  logic              fill_valid,
    input  logic [DW-1:0]     fill_data,
    input  logic [N_ELEM-1:0] rel_evt,
    output logic              cfg_we,
    output logic [EW-1:0]     cfg_elem,
    output logic [FW-1:0]     cfg_field,
    output logic [DW-1:0]     cfg_data,
    output logic              cfg_partial,
    output logic [N_ELEM-1:0] elem_cfgd
);
    lcm_state_e state_q, state_d;
    lcm_op_e    op_q;
    logic [ID_W-1:0] id_q;
    logic [SW-1:0]   slot_q, rr_q;
    logic [EW-1:0]   elem_q;
    logic [FW-1:0]   field_q;
    logic [BW-1:0]   beat_q;

    logic q_push, q_pop, q_empty, q_full;
    logic [QW-1:0] q_din, q_dout;

    logic lk_hit;
    logic [SW-1:0] lk_slot;
    logic [N_ELEM-1:0] lk_emask, rd_emask, set_vec, mgr_clr;
    logic [FIELDS-1:0] rd_fmask;
    logic rd_diff;
    logic [DW-1:0] rd_word;
    logic hdr_we, dat_we, adv_field, adv_elem;
    logic last_field, last_elem, last_beat, tgt_hit, cur_busy;

    assign req_ready = !q_full && !evt_valid;
    assign q_push    = (evt_valid && !q_full) || (req_valid && req_ready);
    assign q_din     = evt_valid ? {evt_op, evt_id} : {req_op, req_id};

    lcm_req_fifo #(.W(QW), .DEPTH(QDEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(q_push), .din(q_din), .pop(q_pop),
        .dout(q_dout), .empty(q_empty), .full(q_full)
    );

    lcm_cfg_cache #(.N_ELEM(N_ELEM), .FIELDS(FIELDS), .NSLOT(NSLOT), .ID_W(ID_W), .DW(DW)) u_cache (
        .clk(clk), .rst_n(rst_n),
        .lk_id(id_q), .lk_hit(lk_hit), .lk_slot(lk_slot), .lk_emask(lk_emask),
        .hdr_we(hdr_we), .hdr_slot(slot_q), .hdr_id(id_q), .hdr_word(fill_data),
        .dat_we(dat_we), .dat_slot(slot_q), .dat_beat(beat_q), .dat_word(fill_data),
        .rd_slot(slot_q), .rd_elem(elem_q), .rd_field(field_q),
        .rd_word(rd_word), .rd_diff(rd_diff), .rd_emask(rd_emask), .rd_fmask(rd_fmask)
    );

    lcm_elem_track #(.N_ELEM(N_ELEM)) u_track (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(rel_evt | mgr_clr), .cfgd(elem_cfgd)
    );

    assign last_field = (field_q == FW'(FIELDS-1));
    assign last_elem  = (elem_q == EW'(N_ELEM-1));
    assign last_beat  = (beat_q == BW'(BEATS-1));
    assign tgt_hit    = rd_emask[elem_q];
    assign cur_busy   = elem_cfgd[elem_q];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (!q_empty) state_d = ST_LOOKUP;
            ST_LOOKUP: begin
                unique case (op_q)
                    OP_LOAD:     state_d = lk_hit ? ST_WRITE : ST_FETCH;
                    OP_PREFETCH: state_d = lk_hit ? ST_IDLE : ST_FETCH;
                    default:     state_d = ST_IDLE;
                endcase
            end
            ST_FETCH:  state_d = ST_HEADER;
            ST_HEADER: if (fill_valid) state_d = ST_FILL;
            ST_FILL:   if (fill_valid && last_beat) state_d = (op_q == OP_LOAD) ? ST_WRITE : ST_IDLE;
            ST_WRITE:  if (adv_elem && last_elem) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs and strobes
    always_comb begin
        q_pop     = 1'b0;
        cfg_we    = 1'b0;
        set_vec   = '0;
        mgr_clr   = '0;
        adv_field = 1'b0;
        adv_elem  = 1'b0;
        hdr_we    = 1'b0;
        dat_we    = 1'b0;
        fetch_req = 1'b0;
        unique case (state_q)
            ST_IDLE:   q_pop = !q_empty;
            ST_LOOKUP: if (op_q == OP_RELEASE && lk_hit) mgr_clr = lk_emask;
            ST_FETCH:  fetch_req = 1'b1;
            ST_HEADER: hdr_we = fill_valid;
            ST_FILL:   dat_we = fill_valid;
            ST_WRITE: begin
                if (!tgt_hit) begin
                    adv_elem = 1'b1;
                end else if (!rd_diff) begin
                    if (!cur_busy) begin
                        cfg_we = 1'b1;
                        if (last_field) begin
                            set_vec[elem_q] = 1'b1;
                            adv_elem = 1'b1;
                        end else begin
                            adv_field = 1'b1;
                        end
                    end
                end else if (!cur_busy) begin
                    adv_elem = 1'b1;
                end else begin
                    cfg_we = rd_fmask[field_q];
                    if (last_field) adv_elem = 1'b1;
                    else            adv_field = 1'b1;
                end
            end
            default: ;
        endcase
    end

    assign fetch_id    = id_q;
    assign cfg_elem    = elem_q;
    assign cfg_field   = field_q;
    assign cfg_data    = rd_word;
    assign cfg_partial = cfg_we && rd_diff;

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q    <= OP_NONE;
            id_q    <= '0;
            slot_q  <= '0;
            rr_q    <= '0;
            elem_q  <= '0;
            field_q <= '0;
            beat_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (q_pop) begin
                    op_q <= lcm_op_e'(q_dout[QW-1:ID_W]);
                    id_q <= q_dout[ID_W-1:0];
                end
                ST_LOOKUP: begin
                    if (lk_hit) slot_q <= lk_slot;
                    elem_q  <= '0;
                    field_q <= '0;
                end
                ST_FETCH: begin
                    slot_q <= rr_q;
                    rr_q   <= (rr_q == SW'(NSLOT-1)) ? '0 : rr_q + 1'b1;
                end
                ST_HEADER: beat_q <= '0;
                ST_FILL:   if (fill_valid) beat_q <= beat_q + 1'b1;
                ST_WRITE: begin
                    if (adv_elem) begin
                        field_q <= '0;
                        elem_q  <= elem_q + 1'b1;
                    end else if (adv_field) begin
                        field_q <= field_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    AST_FULL_TO_FREE: assert property (@(posedge clk) disable iff (!rst_n) (cfg_we && !cfg_partial) |-> !elem_cfgd[cfg_elem]); // R3
    AST_DIFF_TO_CFGD: assert property (@(posedge clk) disable iff (!rst_n) (cfg_we && cfg_partial) |-> elem_cfgd[cfg_elem]); // R5
    AST_CFGD_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n) (cfg_we && !cfg_partial && cfg_field == FW'(FIELDS-1)) |=> elem_cfgd[$past(cfg_elem)]); // R4
    AST_FETCH_PULSE: assert property (@(posedge clk) disable iff (!rst_n) fetch_req |=> !fetch_req); // R6
    AST_WRITE_ONLY_LOAD: assert property (@(posedge clk) disable iff (!rst_n) cfg_we |-> (op_q == OP_LOAD)); // R7

endmodule

// File: tb/lcm_leaf_mgr_tb_top.sv
module lcm_leaf_mgr_tb_top;
    import lcm_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_op = 2'd0;
    logic [3:0] req_id = 4'd0;
    logic req_ready;
    logic evt_valid = 1'b0;
    logic [1:0] evt_op = 2'd0;
    logic [3:0] evt_id = 4'd0;
    logic fetch_req;
    logic [3:0] fetch_id;
    logic fill_valid = 1'b0;
    logic [15:0] fill_data = 16'd0;
    logic [3:0] rel_evt = 4'd0;
    logic cfg_we;
    logic [1:0] cfg_elem;
    logic [1:0] cfg_field;
    logic [15:0] cfg_data;
    logic cfg_partial;
    logic [3:0] elem_cfgd;

    int checks = 0;
    int errors = 0;
    int fetch_cnt = 0;
    int last_fetch = -1;
    int lg_n = 0;
    int ex_n = 0;
    int lg [64];
    int ex [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    lcm_leaf_mgr dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_op(req_op), .req_id(req_id), .req_ready(req_ready),
        .evt_valid(evt_valid), .evt_op(evt_op), .evt_id(evt_id),
        .fetch_req(fetch_req), .fetch_id(fetch_id),
        .fill_valid(fill_valid), .fill_data(fill_data), .rel_evt(rel_evt),
        .cfg_we(cfg_we), .cfg_elem(cfg_elem), .cfg_field(cfg_field), .cfg_data(cfg_data),
        .cfg_partial(cfg_partial), .elem_cfgd(elem_cfgd)
    );

    // configuration contents held by the parent
    function automatic void cfg_of(input int id, output logic [3:0] em, output logic [3:0] fm, output logic df);
        em = 4'b0000; fm = 4'b0000; df = 1'b0;
        case (id)
            1: em = 4'b0011;
            2: em = 4'b0110;
            3: em = 4'b1001;
            4: begin em = 4'b0011; fm = 4'b0101; df = 1'b1; end
            5: em = 4'b1100;
            6: em = 4'b0010;
            default: ;
        endcase
    endfunction

    function automatic logic [15:0] word_of(input int id, input int e, input int f);
        return 16'((id << 8) | (e << 4) | f);
    endfunction

    function automatic int enc(input int p, input int e, input int f, input int d);
        return (p << 24) | (e << 20) | (f << 16) | d;
    endfunction

    // bus and fetch monitor
    always @(negedge clk) begin
        if (rst_n && cfg_we && lg_n < 64) begin
            lg[lg_n] = enc(int'(cfg_partial), int'(cfg_elem), int'(cfg_field), int'(cfg_data));
            lg_n++;
        end
        if (rst_n && fetch_req) begin
            fetch_cnt++;
            last_fetch = int'(fetch_id);
        end
    end

    // parent fill model
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && fetch_req) begin
                automatic int id = int'(fetch_id);
                automatic logic [3:0] em, fm;
                automatic logic df;
                cfg_of(id, em, fm, df);
                @(negedge clk);
                fill_valid = 1'b1;
                fill_data  = {df, 7'd0, fm, em};
                for (int b = 0; b < 16; b++) begin
                    @(negedge clk);
                    fill_data = word_of(id, b / 4, b % 4);
                end
                @(negedge clk);
                fill_valid = 1'b0;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic clear_logs();
        lg_n = 0;
        ex_n = 0;
    endtask

    task automatic exp_elem(input int id, input int e);
        logic [3:0] em, fm;
        logic df;
        cfg_of(id, em, fm, df);
        for (int f = 0; f < 4; f++) begin
            if (!df || fm[f]) begin
                ex[ex_n] = enc(int'(df), e, f, int'(word_of(id, e, f)));
                ex_n++;
            end
        end
    endtask

    task automatic check_log(input string req);
        chk(lg_n == ex_n, req, lg_n, ex_n);
        for (int i = 0; i < ex_n && i < lg_n; i++) begin
            chk(lg[i] == ex[i], req, lg[i], ex[i]);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [1:0] op, input logic [3:0] id);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_id = id;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic send_evt(input logic [1:0] op, input logic [3:0] id);
        @(negedge clk);
        evt_valid = 1'b1; evt_op = op; evt_id = id;
        @(negedge clk);
        evt_valid = 1'b0;
    endtask

    task automatic pulse_rel(input logic [3:0] m);
        @(negedge clk);
        rel_evt = m;
        @(negedge clk);
        rel_evt = 4'd0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int f0;
        settle(3);
        // R1: reset state
        chk(elem_cfgd == 4'b0, "R1 elem state", int'(elem_cfgd), 0);
        chk(!cfg_we && !fetch_req, "R1 bus idle", int'({cfg_we, fetch_req}), 0);
        chk(req_ready, "R1 ready", int'(req_ready), 1);
        rst_n = 1'b1;
        settle(2);

        // R2 R6: first load fetches and writes both targets in order
        clear_logs(); f0 = fetch_cnt;
        send(OP_LOAD, 4'd1); settle(60);
        exp_elem(1, 0); exp_elem(1, 1);
        check_log("R2 full load order");
        chk(fetch_cnt - f0 == 1, "R6 fetch count", fetch_cnt - f0, 1);
        chk(last_fetch == 1, "R6 fetch id", last_fetch, 1);
        chk(elem_cfgd == 4'b0011, "R4 configured", int'(elem_cfgd), 3);

        // R5: differential on configured elements
        clear_logs();
        send(OP_LOAD, 4'd4); settle(60);
        exp_elem(4, 0); exp_elem(4, 1);
        check_log("R5 differential fields");
        chk(elem_cfgd == 4'b0011, "R5 state unchanged", int'(elem_cfgd), 3);

        // R3: load overlapping a configured element stalls, then resumes
        clear_logs();
        send(OP_LOAD, 4'd2); settle(60);
        chk(lg_n == 0, "R3 stalled no write", lg_n, 0);
        chk(elem_cfgd == 4'b0011, "R3 stalled state", int'(elem_cfgd), 3);
        pulse_rel(4'b0010); settle(30);
        exp_elem(2, 1); exp_elem(2, 2);
        check_log("R3 resume after release");
        chk(elem_cfgd == 4'b0111, "R3 resumed state", int'(elem_cfgd), 7);

        // R9: manager release of a cached configuration
        f0 = fetch_cnt;
        send(OP_RELEASE, 4'd2); settle(10);
        chk(elem_cfgd == 4'b0001, "R9 release request", int'(elem_cfgd), 1);
        chk(fetch_cnt == f0, "R9 no fetch", fetch_cnt - f0, 0);

        // R10 R9: event-driven release and load
        send_evt(OP_RELEASE, 4'd1); settle(10);
        chk(elem_cfgd == 4'b0000, "R10 event release", int'(elem_cfgd), 0);
        clear_logs();
        send_evt(OP_LOAD, 4'd3); settle(60);
        exp_elem(3, 0); exp_elem(3, 3);
        check_log("R10 event load");
        chk(elem_cfgd == 4'b1001, "R10 event load state", int'(elem_cfgd), 9);

        // R4: partial progress while a later target is held
        clear_logs();
        send(OP_LOAD, 4'd5); settle(60);
        exp_elem(5, 2);
        check_log("R4 partial progress");
        chk(elem_cfgd == 4'b1101, "R4 early element configured", int'(elem_cfgd), 13);
        clear_logs();
        pulse_rel(4'b1000); settle(30);
        exp_elem(5, 3);
        check_log("R3 tail after release");
        chk(elem_cfgd == 4'b1101, "R3 tail state", int'(elem_cfgd), 13);

        // R7 R8: prefetch then load from cache
        clear_logs(); f0 = fetch_cnt;
        send(OP_PREFETCH, 4'd6); settle(40);
        chk(fetch_cnt - f0 == 1, "R7 prefetch fetches", fetch_cnt - f0, 1);
        chk(lg_n == 0, "R7 prefetch no write", lg_n, 0);
        chk(elem_cfgd == 4'b1101, "R7 prefetch state", int'(elem_cfgd), 13);
        f0 = fetch_cnt;
        send(OP_LOAD, 4'd6); settle(40);
        chk(fetch_cnt == f0, "R8 resident no fetch", fetch_cnt - f0, 0);
        exp_elem(6, 1);
        check_log("R8 resident load");
        chk(elem_cfgd == 4'b1111, "R8 resident state", int'(elem_cfgd), 15);

        // R8: round-robin eviction after NSLOT new fetches
        f0 = fetch_cnt;
        for (int k = 7; k <= 10; k++) begin
            send(OP_PREFETCH, 4'(k)); settle(30);
        end
        chk(fetch_cnt - f0 == 4, "R8 four misses", fetch_cnt - f0, 4);
        f0 = fetch_cnt;
        send(OP_PREFETCH, 4'd6); settle(30);
        chk(fetch_cnt - f0 == 1, "R8 evicted refetch", fetch_cnt - f0, 1);
        f0 = fetch_cnt;
        send(OP_PREFETCH, 4'd6); settle(10);
        chk(fetch_cnt == f0, "R8 hit after refetch", fetch_cnt - f0, 0);

        // R5: differential on free elements is skipped
        pulse_rel(4'b1111); settle(2);
        chk(elem_cfgd == 4'b0000, "R9 array release all", int'(elem_cfgd), 0);
        clear_logs();
        send(OP_LOAD, 4'd4); settle(60);
        chk(lg_n == 0, "R5 free targets skipped", lg_n, 0);
        chk(elem_cfgd == 4'b0000, "R5 free state", int'(elem_cfgd), 0);

        // R10: queued requests keep arrival order
        clear_logs();
        send(OP_LOAD, 4'd1);
        send(OP_RELEASE, 4'd1);
        send(OP_LOAD, 4'd3);
        settle(120);
        exp_elem(1, 0); exp_elem(1, 1); exp_elem(3, 0); exp_elem(3, 3);
        check_log("R10 queue order");
        chk(elem_cfgd == 4'b1001, "R10 queue final state", int'(elem_cfgd), 9);

        // R10: event port wins over parent in the same cycle
        clear_logs();
        @(negedge clk);
        evt_valid = 1'b1; evt_op = OP_RELEASE; evt_id = 4'd3;
        req_valid = 1'b1; req_op = OP_LOAD; req_id = 4'd5;
        #1;
        chk(!req_ready, "R10 ready low on event", int'(req_ready), 0);
        @(negedge clk);
        evt_valid = 1'b0;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        settle(80);
        exp_elem(5, 2); exp_elem(5, 3);
        check_log("R10 event priority");
        chk(elem_cfgd == 4'b1100, "R10 priority state", int'(elem_cfgd), 12);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule